// File: doc/BRIEF.md
# Dual-Buck Inverter Gate Sequencer

This block drives the four power switches of a single-phase dual-buck full-bridge inverter. The inverter is made of two buck stages. One carries positive grid current through a fast switch (`gate_p_hf_o`) and a slow switch (`gate_p_lf_o`). The other carries negative current through its own fast/slow pair (`gate_n_hf_o`, `gate_n_lf_o`). Only one stage is active at a time. In that stage the slow switch stays on for the whole half cycle and the fast switch is pulse-width modulated. Both switches of the idle stage are held off. No two switches share a leg, so no dead time is inserted.

A free-running carrier counter defines the switching period. The default is 500 clocks, which gives 400 kHz from a 200 MHz clock. At every period boundary the block latches a duty word, clamped to the period length. It also decides the active stage from a hysteresis-filtered sign of the signed current reference. A change of stage passes through one full period with every gate low. A fault input blanks the gates in the same cycle. The block stays off until the fault is gone and the enable has been taken low and raised again.

Top module: `dbuck_gate_seq`

## Requirements
- R1: After reset, and while `en_i` is low, all four gates are low and `phase_o` reads 0 (idle).
- R2: The carrier counter starts at 0 at reset release and counts 0..PERIOD-1, then wraps. In the positive phase (`phase_o`=1), `gate_p_hf_o` is high during counts 0..duty-1 of each period. `gate_p_lf_o` is high for the whole period, and both negative gates are low.
- R3: In the negative phase (`phase_o`=2), `gate_n_hf_o` is high during counts 0..duty-1. `gate_n_lf_o` is high for the whole period, and both positive gates are low.
- R4: The duty word is sampled only at the period boundary. A change during a period does not alter that period's pulse width and takes effect in the next period.
- R5: A duty of 0 gives no fast-switch pulse. A duty equal to or above PERIOD is clamped so that the fast switch is on for all PERIOD counts.
- R6: A change of polarity takes effect only at a period boundary. The block then spends exactly one period in the blanking phase (`phase_o`=3) with all gates low, and then enters the new phase.
- R7: The polarity flag becomes positive when the reference exceeds +HYST and negative when it is below -HYST. Inside the band -HYST..+HYST the previous flag is kept, and the phase does not change.
- R8: While `fault_i` is high, all gates are low in that same cycle. After `fault_i` clears, the gates stay low and the phase stays idle until `en_i` has been low for at least one clock and is raised again.
- R9: The positive and negative stages are never on together, and a fast switch is never on without its own slow switch.
- R10: When the block starts from idle, it enters the phase given by the filtered polarity at the next period boundary, with no blanking period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable |
| fault_i | input | 1 | Fault, blanks all gates |
| duty_i | input | DUTY_W | Fast-switch on-time in clocks, latched per period |
| iref_i | input | REF_W | Signed current reference; its filtered sign selects the stage |
| gate_p_hf_o | output | 1 | Positive stage fast switch |
| gate_p_lf_o | output | 1 | Positive stage slow switch |
| gate_n_hf_o | output | 1 | Negative stage fast switch |
| gate_n_lf_o | output | 1 | Negative stage slow switch |
| phase_o | output | 2 | 0 idle, 1 positive, 2 negative, 3 blanking |

## Verification
The assertions check the following on every cycle:
- the two stages are never on together;
- a fast switch is never on without its slow switch;
- a positive phase never turns straight into a negative one;
- the phase moves only on a period boundary;
- the latched duty never exceeds the period;
- the polarity flag is held inside the hysteresis band;
- a fault always sends the sequencer to idle.

Only the directed scenarios can show the rest. They cover:
- exact pulse widths per period;
- the one-period lag of a mid-period duty change;
- the single blanking period and its timing against the boundary;
- the band edges at ±HYST;
- the need to cycle the enable before restarting after a fault.

// File: rtl/dbuck_pkg.sv
package dbuck_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_POS   = 2'd1,
    PH_NEG   = 2'd2,
    PH_BLANK = 2'd3
  } phase_e;
endpackage

// File: rtl/dbuck_carrier.sv
module dbuck_carrier #(
  parameter int PERIOD = 500,
  localparam int CNT_W = $clog2(PERIOD)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  assign last_o = (cnt_q == CNT_W'(PERIOD - 1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (last_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R2: counter stays inside the period
  a_r2_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(PERIOD - 1));
endmodule

// File: rtl/dbuck_polarity.sv
module dbuck_polarity #(
  parameter int REF_W = 12,
  parameter int HYST  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [REF_W-1:0] iref_i,
  output logic                    pos_o
);
  localparam logic signed [REF_W-1:0] BAND = REF_W'(HYST);

  logic above, below;
  assign above = (iref_i > BAND);
  assign below = (iref_i < -BAND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pos_o <= 1'b1;
    else if (above) pos_o <= 1'b1;
    else if (below) pos_o <= 1'b0;
  end

  // R7: inside the band the flag is held
  a_r7_band_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iref_i <= BAND && iref_i >= -BAND) |=> $stable(pos_o));
endmodule

// File: rtl/dbuck_phase_fsm.sv
module dbuck_phase_fsm
  import dbuck_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   run_i,
  input  logic   last_i,
  input  logic   pos_i,
  output phase_e phase_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (!run_i) begin
      phase_d = PH_IDLE;
    end else if (last_i) begin
      unique case (phase_q)
        PH_IDLE:  phase_d = pos_i ? PH_POS : PH_NEG;
        PH_POS:   phase_d = pos_i ? PH_POS : PH_BLANK;
        PH_NEG:   phase_d = pos_i ? PH_BLANK : PH_NEG;
        PH_BLANK: phase_d = pos_i ? PH_POS : PH_NEG;
        default:  phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  // R6: no direct flip between the stages
  a_r6_no_direct_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_POS) |=> (phase_q != PH_NEG));
  a_r6_no_direct_flip_n: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_NEG) |=> (phase_q != PH_POS));
  // R6: phase moves only at the boundary while running
  a_r6_boundary_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !last_i) |=> $stable(phase_q));
endmodule

// File: rtl/dbuck_gate_seq.sv
module dbuck_gate_seq
  import dbuck_pkg::*;
#(
  parameter int PERIOD = 500,
  parameter int DUTY_W = 9,
  parameter int REF_W  = 12,
  parameter int HYST   = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    fault_i,
  input  logic [DUTY_W-1:0]       duty_i,
  input  logic signed [REF_W-1:0] iref_i,
  output logic                    gate_p_hf_o,
  output logic                    gate_p_lf_o,
  output logic                    gate_n_hf_o,
  output logic                    gate_n_lf_o,
  output logic [1:0]              phase_o
);
  localparam int CNT_W = $clog2(PERIOD);
  localparam int CMP_W = (DUTY_W > CNT_W) ? DUTY_W : CNT_W;
  localparam logic [DUTY_W-1:0] DUTY_MAX = DUTY_W'(PERIOD);

  logic [CNT_W-1:0]  cnt;
  logic              last;
  logic              pos;
  logic              run;
  logic              lock_q;
  logic [DUTY_W-1:0] duty_q;
  logic              hf_on;
  logic              blank;
  phase_e            phase;

  dbuck_carrier #(.PERIOD(PERIOD)) u_carrier (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt),
    .last_o(last)
  );

  dbuck_polarity #(.REF_W(REF_W), .HYST(HYST)) u_pol (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .iref_i(iref_i),
    .pos_o (pos)
  );

  // lock holds after a fault until enable drops with the fault gone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lock_q <= 1'b0;
    else if (fault_i)           lock_q <= 1'b1;
    else if (!en_i)             lock_q <= 1'b0;
  end

  assign run = en_i & ~fault_i & ~lock_q;

  dbuck_phase_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .last_i (last),
    .pos_i  (pos),
    .phase_o(phase)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   duty_q <= '0;
    else if (last) duty_q <= (duty_i > DUTY_MAX) ? DUTY_MAX : duty_i;
  end

  assign hf_on = (CMP_W'(cnt) < CMP_W'(duty_q));
  assign blank = fault_i | lock_q;

  assign gate_p_lf_o = ~blank & (phase == PH_POS);
  assign gate_n_lf_o = ~blank & (phase == PH_NEG);
  assign gate_p_hf_o = ~blank & (phase == PH_POS) & hf_on;
  assign gate_n_hf_o = ~blank & (phase == PH_NEG) & hf_on;
  assign phase_o     = phase;

  // R9: stages mutually exclusive
  a_r9_stage_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((gate_p_hf_o | gate_p_lf_o) & (gate_n_hf_o | gate_n_lf_o)));
  // R9: fast switch only with its slow switch
  a_r9_hf_needs_lf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_p_hf_o |-> gate_p_lf_o) and (gate_n_hf_o |-> gate_n_lf_o));
  // R5: latched duty never exceeds the period
  a_r5_duty_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_q <= DUTY_MAX);
  // R8: a fault returns the sequencer to idle
  a_r8_fault_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> (phase == PH_IDLE));
endmodule

// File: tb/sim_dbuck_gate_seq.sv
module sim_dbuck_gate_seq;
  localparam int CLK_T = 10;
  localparam int P     = 500;
  localparam int HYST  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, fault = 1'b0;
  logic [8:0] duty = '0;
  logic signed [11:0] iref = '0;
  logic g_ph, g_pl, g_nh, g_nl;
  logic [1:0] ph;
  int bc;
  int n_chk = 0, n_bad = 0;

  always #(CLK_T/2) clk = ~clk;

  dbuck_gate_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .fault_i(fault),
    .duty_i(duty), .iref_i(iref),
    .gate_p_hf_o(g_ph), .gate_p_lf_o(g_pl),
    .gate_n_hf_o(g_nh), .gate_n_lf_o(g_nl), .phase_o(ph)
  );

  // bench's own count of the carrier position (R2)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) bc <= 0;
    else        bc <= (bc == P-1) ? 0 : bc + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sync();
    do @(negedge clk); while (bc != 0);
  endtask

  // sample one full period starting at the current negedge (bc==0)
  task automatic meas(output int a, output int b, output int c, output int d,
                      output int p0);
    a = 0; b = 0; c = 0; d = 0; p0 = int'(ph);
    for (int i = 0; i < P; i++) begin
      if (i != 0) @(negedge clk);
      a += int'(g_ph); b += int'(g_pl); c += int'(g_nh); d += int'(g_nl);
    end
  endtask

  task automatic t_reset();
    int a, b, c, d, p;
    chk("R1 phase after reset", int'(ph), 0);
    chk("R1 gates after reset", int'({g_ph, g_pl, g_nh, g_nl}), 0);
    sync();
    meas(a, b, c, d, p);
    chk("R1 gates idle period", a + b + c + d, 0);
  endtask

  task automatic t_start_pos();
    int a, b, c, d, p;
    sync();
    iref = 12'sd100; duty = 9'd100; en = 1'b1;
    sync();
    meas(a, b, c, d, p);
    chk("R10 first phase positive", p, 1);
    chk("R2 hf width", a, 100);
    chk("R2 lf whole period", b, P);
    chk("R2 neg stage off", c + d, 0);
  endtask

  task automatic t_duty();
    int a, b, c, d, p;
    sync(); duty = 9'd0; sync();
    meas(a, b, c, d, p);
    chk("R5 duty zero", a, 0);
    sync(); duty = 9'd500; sync();
    meas(a, b, c, d, p);
    chk("R5 duty full", a, P);
    sync(); duty = 9'd511; sync();
    meas(a, b, c, d, p);
    chk("R5 duty clamped", a, P);
    chk("R5 lf with clamp", b, P);
    sync(); duty = 9'd100; sync();
    a = 0;
    for (int i = 0; i < P; i++) begin
      if (i != 0) @(negedge clk);
      if (i == 200) duty = 9'd300;
      a += int'(g_ph);
    end
    chk("R4 mid-period change ignored", a, 100);
    @(negedge clk);
    meas(a, b, c, d, p);
    chk("R4 new duty next period", a, 300);
  endtask

  task automatic t_flip();
    int a, b, c, d, p;
    sync();
    repeat (100) @(negedge clk);
    iref = -12'sd100;
    b = 0;
    for (int i = 100; i < P; i++) begin
      b += int'(g_pl);
      if (i != P-1) @(negedge clk);
    end
    chk("R6 lf held till boundary", b, P - 100);
    @(negedge clk);
    meas(a, b, c, d, p);
    chk("R6 blank phase code", p, 3);
    chk("R6 blank gates low", a + b + c + d, 0);
    @(negedge clk);
    meas(a, b, c, d, p);
    chk("R3 negative phase code", p, 2);
    chk("R3 hf width", c, 300);
    chk("R3 lf whole period", d, P);
    chk("R3 pos stage off", a + b, 0);
  endtask

  task automatic t_hyst();
    int a, b, c, d, p;
    sync(); iref = 12'sd4; sync(); sync();
    meas(a, b, c, d, p);
    chk("R7 +HYST holds negative", p, 2);
    sync(); iref = 12'sd5; sync();
    meas(a, b, c, d, p);
    chk("R7 above band leaves negative", p, 3);
    @(negedge clk);
    meas(a, b, c, d, p);
    chk("R7 positive after blank", p, 1);
    sync(); iref = -12'sd4; sync(); sync();
    meas(a, b, c, d, p);
    chk("R7 -HYST holds positive", p, 1);
    chk("R7 lf still on", b, P);
  endtask

  task automatic t_fault();
    int a, b, c, d, p;
    iref = 12'sd100;
    sync();
    repeat (50) @(negedge clk);
    chk("R8 lf on before fault", int'(g_pl), 1);
    fault = 1'b1;
    #1;
    chk("R8 gates low same cycle", int'({g_ph, g_pl, g_nh, g_nl}), 0);
    @(negedge clk);
    fault = 1'b0;
    sync(); sync();
    meas(a, b, c, d, p);
    chk("R8 stays off with enable held", a + b + c + d, 0);
    chk("R8 idle phase", p, 0);
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1;
    sync();
    meas(a, b, c, d, p);
    chk("R8 restart positive", p, 1);
    chk("R8 restart lf", b, P);
  endtask

  initial begin
    #(CLK_T * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_start_pos();
    t_duty();
    t_flip();
    t_hyst();
    t_fault();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule